// File: doc/BRIEF.md
# Segmented Bus Switch Controller

This block steers an 8-bit shared on-chip bus that has been split into segments arranged as a tree, with one unit (arithmetic unit, RAM, ROM, timer, I/O ports) attached to each segment. A switch on each tree edge joins a segment to its parent. Each instruction states a sender, a receiver, a length in machine cycles, the machine cycle and stage in which the transfer happens, and whether it is a rarely used instruction. From these the block closes only the switches on the tree path between the two units. It also drives the precharge strobe, the sender's drive enable and the receiver's latch enable.

Timing comes from an internal sequencer. Each clock is one phase. Every stage has a precharge phase followed by an evaluation phase, a machine cycle is six stages, and an instruction is 1, 2 or 4 machine cycles long. A normal instruction closes its path switches only during the stage it transfers in. A rarely used instruction keeps them closed for the whole instruction, which trades bus energy for simpler gating and must give the same bus result.

The block contains a synthesizable model of the dynamic bus. All segments read all-ones while precharged. During evaluation a segment takes the sender's data only when every switch between it and the sender is closed. A receive register captures the receiver's segment when the latch enable fires. The tree shape is a parameter that gives each node's parent.

Top module: `sbus_ctrl`

## Requirements
- R1: Under reset, and on the first clock after it, the sequencer is at machine cycle 0, stage 0, phase 0 and `rx_data` is 0. The sequencer advances one phase per clock in the order phase 0, phase 1, next stage.
- R2: `precharge` is high exactly in phase 0 of every stage. While it is high every segment in `seg_val` reads all-ones.
- R3: `sw_close[j]` controls the switch between node j+1 and its parent. Only switches on the unique tree path between `src_id` and `dst_id` ever close.
- R4: For a normal instruction (`rare_op`=0), the path switches are closed only in the clocks where the machine cycle equals `xfer_cycle` and the stage equals `xfer_stage`, in both phases. In all other clocks every switch is open.
- R5: For a rarely used instruction (`rare_op`=1), the path switches are closed on every clock of the instruction. The value captured in `rx_data` is the same as in the normal mode.
- R6: `drive_en` (one-hot, bit = sender ID) and `latch_en` (one-hot, bit = receiver ID) are asserted only in phase 1 of the transfer stage of the transfer machine cycle.
- R7: During evaluation with a drive active, every segment joined to the sender through closed switches carries the sender's `unit_tx` byte. Every other segment stays all-ones, and only the sender's byte can pull lines low.
- R8: On the clock after `latch_en` is asserted, `rx_data` holds the receiver's segment value from the latch clock.
- R9: `seg_cnt` is the tree distance between sender and receiver plus one for a valid transfer, and 0 otherwise.
- R10: If `xfer_valid` is 0, or `src_id` equals `dst_id`, or either ID is not below the unit count, no switch closes, no drive or latch enable asserts and `rx_data` is unchanged.
- R11: `len_code` 0, 1 and 2 give 1, 2 and 4 machine cycles, and 3 also gives 4. `instr_end` is high only in the final phase of the final stage of the final machine cycle, after which the sequencer returns to cycle 0, stage 0, phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_valid | input | 1 | The current instruction performs a bus transfer |
| src_id | input | 3 | Sending unit / segment index |
| dst_id | input | 3 | Receiving unit / segment index |
| len_code | input | 2 | Instruction length code (R11) |
| rare_op | input | 1 | Rarely used instruction: keep path switches closed all instruction |
| xfer_cycle | input | 2 | Machine cycle of the transfer |
| xfer_stage | input | 3 | Stage (0..5) of the transfer |
| unit_tx | input | 48 | Byte offered by each unit, unit i at bits [8i+7:8i] |
| sw_close | output | 5 | Switch enables, bit j joins node j+1 to its parent |
| precharge | output | 1 | Precharge strobe |
| drive_en | output | 6 | One-hot sender drive enable |
| latch_en | output | 6 | One-hot receiver latch enable |
| seg_cnt | output | 3 | Segments crossed by the transfer |
| seg_val | output | 48 | Modelled value of each segment |
| rx_data | output | 8 | Last byte latched by a receiver |
| instr_end | output | 1 | Last clock of the instruction |

## Verification
On every cycle the assertions check that precharge forces all segments high, that the sequencer wraps cleanly after `instr_end`, that drive is one-hot and latch never fires without it, that the closed switch count agrees with `seg_cnt` while driving, that equal IDs never close a switch, and that `rx_data` follows the latched segment. Only the bench's scenarios can show that the right switches close for a given tree path, that the stage window is honoured in the normal mode and widened in the rare mode with the same received byte, that segments off the path stay all-ones, and that the three instruction lengths end at the right clock.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

   localparam int MAX_NODES = 32;

   // Machine-cycle index of the last cycle for a length code (1, 2, 4, 4).
   function automatic logic [1:0] last_cycle(input logic [1:0] code);
      case (code)
         2'd0:    return 2'd0;
         2'd1:    return 2'd1;
         default: return 2'd3;
      endcase
   endfunction

   // Ancestor table: bit a*n+x set when node a lies on the chain from x to the root.
   function automatic logic [MAX_NODES*MAX_NODES-1:0] anc_table(
      input logic [MAX_NODES*8-1:0] pmap, input int n);
      logic [MAX_NODES*MAX_NODES-1:0] t;
      int cur;
      logic done;
      t = '0;
      for (int a = 0; a < n; a++) begin
         for (int x = 0; x < n; x++) begin
            cur  = x;
            done = 1'b0;
            for (int s = 0; s <= n; s++) begin
               if (!done) begin
                  if (cur == a) begin
                     t[a*n + x] = 1'b1;
                     done       = 1'b1;
                  end else if (cur == 0) begin
                     done = 1'b1;
                  end else begin
                     cur = int'(pmap[cur*8 +: 8]);
                  end
               end
            end
         end
      end
      return t;
   endfunction

endpackage

// File: rtl/sbus_seq.sv
module sbus_seq #(
   parameter int STAGES = 6,
   parameter int PHASES = 2,
   localparam int STW = $clog2(STAGES),
   localparam int PHW = (PHASES > 2) ? $clog2(PHASES) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [1:0]     len_code,
   output logic [PHW-1:0] phase,
   output logic [STW-1:0] stage,
   output logic [1:0]     mcyc,
   output logic           instr_end
);
   localparam logic [STW-1:0] ST_LAST = STW'(STAGES - 1);
   localparam logic [PHW-1:0] PH_LAST = PHW'(PHASES - 1);

   logic [1:0] last_mc;
   assign last_mc   = sbus_pkg::last_cycle(len_code);
   assign instr_end = (phase == PH_LAST) && (stage == ST_LAST) && (mcyc >= last_mc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
         stage <= '0;
         mcyc  <= '0;
      end else if (phase == PH_LAST) begin
         phase <= '0;
         if (stage == ST_LAST) begin
            stage <= '0;
            mcyc  <= (mcyc >= last_mc) ? 2'd0 : mcyc + 2'd1;
         end else begin
            stage <= stage + 1'b1;
         end
      end else begin
         phase <= phase + 1'b1;
      end
   end

   // R1/R11: an instruction boundary returns the sequencer to its origin
   a_r11_wrap_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      instr_end |=> (phase == '0 && stage == '0 && mcyc == 2'd0));
   a_r1_stage_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      stage <= ST_LAST);
endmodule

// File: rtl/sbus_path.sv
module sbus_path #(
   parameter int N_UNITS = 6,
   parameter logic [N_UNITS*8-1:0] PARENT_MAP = '0,
   localparam int IDW  = $clog2(N_UNITS),
   localparam int CNTW = $clog2(N_UNITS + 1)
) (
   input  logic [IDW-1:0]     src,
   input  logic [IDW-1:0]     dst,
   input  logic               ok,
   output logic [N_UNITS-2:0] path,
   output logic [CNTW-1:0]    cnt
);
   localparam logic [sbus_pkg::MAX_NODES*8-1:0] PM_EXT =
      (sbus_pkg::MAX_NODES*8)'(PARENT_MAP);
   localparam logic [sbus_pkg::MAX_NODES*sbus_pkg::MAX_NODES-1:0] ANC =
      sbus_pkg::anc_table(PM_EXT, N_UNITS);

   // An edge is on the path when exactly one endpoint lies under its child node.
   for (genvar k = 1; k < N_UNITS; k++) begin : g_edge
      assign path[k-1] = ok && (ANC[k*N_UNITS + int'(src)] != ANC[k*N_UNITS + int'(dst)]);
   end

   assign cnt = ok ? CNTW'($countones(path) + 1) : '0;
endmodule

// File: rtl/sbus_busmodel.sv
module sbus_busmodel #(
   parameter int N_UNITS = 6,
   parameter int DW = 8,
   parameter logic [N_UNITS*8-1:0] PARENT_MAP = '0
) (
   input  logic [N_UNITS-2:0]    sw_close,
   input  logic [N_UNITS-1:0]    drive,
   input  logic                  precharge,
   input  logic [N_UNITS*DW-1:0] unit_tx,
   output logic [N_UNITS*DW-1:0] seg_val
);
   localparam logic [sbus_pkg::MAX_NODES*8-1:0] PM_EXT =
      (sbus_pkg::MAX_NODES*8)'(PARENT_MAP);
   localparam logic [sbus_pkg::MAX_NODES*sbus_pkg::MAX_NODES-1:0] ANC =
      sbus_pkg::anc_table(PM_EXT, N_UNITS);

   logic          joined;
   logic [DW-1:0] level;

   // Dynamic bus: precharged high, a line falls only if a joined driver pulls it low.
   always_comb begin
      seg_val = '1;
      joined  = 1'b0;
      level   = '1;
      for (int x = 0; x < N_UNITS; x++) begin
         level = '1;
         for (int s = 0; s < N_UNITS; s++) begin
            joined = drive[s];
            for (int k = 1; k < N_UNITS; k++) begin
               if ((ANC[k*N_UNITS + s] != ANC[k*N_UNITS + x]) && !sw_close[k-1])
                  joined = 1'b0;
            end
            if (joined) level = level & unit_tx[s*DW +: DW];
         end
         if (precharge) level = '1;
         seg_val[x*DW +: DW] = level;
      end
   end
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl #(
   parameter int N_UNITS = 6,
   parameter int DW      = 8,
   parameter int STAGES  = 6,
   parameter int PHASES  = 2,
   parameter logic [N_UNITS*8-1:0] PARENT_MAP = 48'h02_01_01_00_00_00,
   localparam int IDW  = $clog2(N_UNITS),
   localparam int CNTW = $clog2(N_UNITS + 1),
   localparam int STW  = $clog2(STAGES),
   localparam int PHW  = (PHASES > 2) ? $clog2(PHASES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  xfer_valid,
   input  logic [IDW-1:0]        src_id,
   input  logic [IDW-1:0]        dst_id,
   input  logic [1:0]            len_code,
   input  logic                  rare_op,
   input  logic [1:0]            xfer_cycle,
   input  logic [STW-1:0]        xfer_stage,
   input  logic [N_UNITS*DW-1:0] unit_tx,
   output logic [N_UNITS-2:0]    sw_close,
   output logic                  precharge,
   output logic [N_UNITS-1:0]    drive_en,
   output logic [N_UNITS-1:0]    latch_en,
   output logic [CNTW-1:0]       seg_cnt,
   output logic [N_UNITS*DW-1:0] seg_val,
   output logic [DW-1:0]         rx_data,
   output logic                  instr_end
);
   // Elaboration-time parameter checks
   if (N_UNITS < 2 || N_UNITS > sbus_pkg::MAX_NODES) begin : g_bad_units
      $error("sbus_ctrl: N_UNITS out of range");
   end
   if (PHASES < 2 || STAGES < 1 || DW < 1) begin : g_bad_timing
      $error("sbus_ctrl: STAGES, PHASES or DW out of range");
   end
   for (genvar i = 1; i < N_UNITS; i++) begin : g_tree_chk
      if (int'(PARENT_MAP[i*8 +: 8]) >= i) begin : g_bad_parent
         $error("sbus_ctrl: parent index must be below child index");
      end
   end

   localparam logic [PHW-1:0] PH_LAST = PHW'(PHASES - 1);

   logic [PHW-1:0]     phase;
   logic [STW-1:0]     stage;
   logic [1:0]         mcyc;
   logic               ids_ok;
   logic               in_window;
   logic [N_UNITS-2:0] path;

   sbus_seq #(.STAGES(STAGES), .PHASES(PHASES)) u_seq (
      .clk(clk), .rst_n(rst_n), .len_code(len_code),
      .phase(phase), .stage(stage), .mcyc(mcyc), .instr_end(instr_end)
   );

   assign ids_ok = xfer_valid && (src_id != dst_id) &&
                   ({1'b0, src_id} < (IDW+1)'(N_UNITS)) &&
                   ({1'b0, dst_id} < (IDW+1)'(N_UNITS));

   sbus_path #(.N_UNITS(N_UNITS), .PARENT_MAP(PARENT_MAP)) u_path (
      .src(src_id), .dst(dst_id), .ok(ids_ok), .path(path), .cnt(seg_cnt)
   );

   assign in_window = ids_ok && (mcyc == xfer_cycle) && (stage == xfer_stage);
   assign precharge = (phase == '0);
   assign sw_close  = (rare_op || in_window) ? path : '0;
   assign drive_en  = (in_window && phase != '0) ? (N_UNITS'(1) << src_id) : '0;
   assign latch_en  = (in_window && phase == PH_LAST) ? (N_UNITS'(1) << dst_id) : '0;

   sbus_busmodel #(.N_UNITS(N_UNITS), .DW(DW), .PARENT_MAP(PARENT_MAP)) u_bus (
      .sw_close(sw_close), .drive(drive_en), .precharge(precharge),
      .unit_tx(unit_tx), .seg_val(seg_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rx_data <= '0;
      else if (|latch_en) rx_data <= seg_val[dst_id*DW +: DW];
   end

   a_r2_precharge_high: assert property (@(posedge clk) disable iff (!rst_n)
      precharge |-> (&seg_val));
   a_r6_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drive_en) && $onehot0(latch_en));
   a_r6_latch_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (|latch_en) |-> (|drive_en) && !precharge);
   a_r8_rx_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (|latch_en) |=> rx_data == $past(seg_val[dst_id*DW +: DW]));
   a_r9_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
      (|drive_en) |-> ($countones(sw_close) + 1 == int'(seg_cnt)));
   a_r10_same_ids_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (src_id == dst_id) |-> (sw_close == '0 && latch_en == '0 && seg_cnt == '0));
endmodule

// File: tb/sbus_ctrl_tb.sv
`timescale 1ns/1ps
module sbus_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_valid = 1'b0;
   logic [2:0]  src_id = '0, dst_id = '0;
   logic [1:0]  len_code = '0;
   logic        rare_op = 1'b0;
   logic [1:0]  xfer_cycle = '0;
   logic [2:0]  xfer_stage = '0;
   logic [47:0] unit_tx = '0;
   logic [4:0]  sw_close;
   logic        precharge;
   logic [5:0]  drive_en, latch_en;
   logic [2:0]  seg_cnt;
   logic [47:0] seg_val;
   logic [7:0]  rx_data;
   logic        instr_end;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   sbus_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .src_id(src_id),
      .dst_id(dst_id), .len_code(len_code), .rare_op(rare_op),
      .xfer_cycle(xfer_cycle), .xfer_stage(xfer_stage), .unit_tx(unit_tx),
      .sw_close(sw_close), .precharge(precharge), .drive_en(drive_en),
      .latch_en(latch_en), .seg_cnt(seg_cnt), .seg_val(seg_val),
      .rx_data(rx_data), .instr_end(instr_end)
   );

   task automatic chk(input string req, input string what, input int k,
                      input logic [63:0] got, input logic [63:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s clk=%0d actual=%h expected=%h", req, what, k, got, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      // R1: reset values visible at the ports
      chk("R1", "precharge in reset", -1, 64'(precharge), 64'd1);
      chk("R1", "rx_data in reset", -1, 64'(rx_data), 64'd0);
      chk("R1", "instr_end in reset", -1, 64'(instr_end), 64'd0);
      rst_n = 1'b1;
   endtask

   // One instruction from reset; tree: 0 root, 1 and 2 under 0, 3 and 4 under 1, 5 under 2.
   task automatic run_instr(input string tag, input logic v, input logic [2:0] s,
                            input logic [2:0] d, input logic [1:0] lc, input logic r,
                            input logic [1:0] xc, input logic [2:0] xs, input logic [7:0] data,
                            input logic [4:0] exp_sw, input logic [5:0] exp_nodes,
                            input logic [2:0] exp_cnt, input logic [7:0] exp_rx);
      int  ncyc;
      bit  ok;
      xfer_valid = v; src_id = s; dst_id = d; len_code = lc; rare_op = r;
      xfer_cycle = xc; xfer_stage = xs;
      unit_tx = '0;
      if (s < 3'd6) unit_tx[s*8 +: 8] = data;
      ncyc = (lc == 2'd0) ? 1 : (lc == 2'd1) ? 2 : 4;
      ok   = v && (s != d) && (s < 3'd6) && (d < 3'd6);
      do_reset();
      chk({tag, "/R9"}, "seg_cnt", 0, 64'(seg_cnt), 64'(exp_cnt));
      for (int k = 0; k < ncyc * 12; k++) begin
         int ph, st, mc;
         bit win, drv;
         logic [4:0]  e_sw;
         logic [5:0]  e_drv, e_lat;
         logic [47:0] e_seg;
         ph  = k % 2;
         st  = (k / 2) % 6;
         mc  = k / 12;
         win = ok && (mc == int'(xc)) && (st == int'(xs));
         drv = win && (ph == 1);
         e_sw  = (ok && (r || win)) ? exp_sw : 5'd0;
         e_drv = drv ? (6'd1 << s) : 6'd0;
         e_lat = drv ? (6'd1 << d) : 6'd0;
         e_seg = '1;
         if (drv) begin
            for (int x = 0; x < 6; x++)
               if (exp_nodes[x]) e_seg[x*8 +: 8] = data;
         end
         chk({tag, "/R3"}, "sw_close", k, 64'(sw_close), 64'(e_sw));
         chk({tag, "/R2"}, "precharge", k, 64'(precharge), 64'(ph == 0));
         chk({tag, "/R6"}, "drive_en", k, 64'(drive_en), 64'(e_drv));
         chk({tag, "/R6"}, "latch_en", k, 64'(latch_en), 64'(e_lat));
         chk({tag, "/R11"}, "instr_end", k, 64'(instr_end), 64'(k == ncyc * 12 - 1));
         chk({tag, "/R7"}, "seg_val", k, 64'(seg_val), 64'(e_seg));
         @(posedge clk);
         @(negedge clk);
      end
      chk({tag, "/R8"}, "rx_data", ncyc * 12, 64'(rx_data), 64'(exp_rx));
      // R1/R11: back at stage 0 phase 0 (precharge) after the instruction
      chk({tag, "/R1"}, "precharge after end", ncyc * 12, 64'(precharge), 64'd1);
   endtask

   // R4: normal mode, unit 0 to unit 1, one edge
   task automatic t_r4_adjacent();
      run_instr("R4", 1'b1, 3'd0, 3'd1, 2'd0, 1'b0, 2'd0, 3'd2, 8'hA5,
                5'b00001, 6'b000011, 3'd2, 8'hA5);
   endtask
   // R5: rare mode, unit 3 to unit 5 across the root, two machine cycles
   task automatic t_r5_long_path();
      run_instr("R5", 1'b1, 3'd3, 3'd5, 2'd1, 1'b1, 2'd1, 3'd4, 8'h3C,
                5'b10111, 6'b101111, 3'd5, 8'h3C);
   endtask
   // R4/R11: siblings 4 to 3, four machine cycles, last stage of last cycle
   task automatic t_r4_siblings();
      run_instr("R4", 1'b1, 3'd4, 3'd3, 2'd2, 1'b0, 2'd3, 3'd5, 8'h0F,
                5'b01100, 6'b011010, 3'd3, 8'h0F);
   endtask
   // R5: same transfer in rare mode latches the identical byte
   task automatic t_r5_same_result();
      run_instr("R5", 1'b1, 3'd4, 3'd3, 2'd2, 1'b1, 2'd3, 3'd5, 8'h0F,
                5'b01100, 6'b011010, 3'd3, 8'h0F);
   endtask
   // R11: length code 3 runs four cycles; unit 1 to unit 2
   task automatic t_r11_code3();
      run_instr("R11", 1'b1, 3'd1, 3'd2, 2'd3, 1'b0, 2'd2, 3'd0, 8'h5A,
                5'b00011, 6'b000111, 3'd3, 8'h5A);
   endtask
   // R5: rare mode to the root, data with mixed bits
   task automatic t_r5_to_root();
      run_instr("R5", 1'b1, 3'd2, 3'd0, 2'd0, 1'b1, 2'd0, 3'd0, 8'hC3,
                5'b00010, 6'b000101, 3'd2, 8'hC3);
   endtask
   // R10: null transfers
   task automatic t_r10_nulls();
      run_instr("R10", 1'b1, 3'd2, 3'd2, 2'd0, 1'b1, 2'd0, 3'd1, 8'h00,
                5'b00000, 6'b000000, 3'd0, 8'h00);
      run_instr("R10", 1'b0, 3'd0, 3'd5, 2'd0, 1'b1, 2'd0, 3'd1, 8'h00,
                5'b00000, 6'b000000, 3'd0, 8'h00);
      run_instr("R10", 1'b1, 3'd7, 3'd1, 2'd0, 1'b1, 2'd0, 3'd1, 8'h00,
                5'b00000, 6'b000000, 3'd0, 8'h00);
   endtask

   initial begin
      t_r4_adjacent();
      t_r5_long_path();
      t_r4_siblings();
      t_r5_same_result();
      t_r11_code3();
      t_r5_to_root();
      t_r10_nulls();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule